// File: doc/BRIEF.md
# Dual-Execution Result Verification Buffer

This block guards against transient faults by checking every instruction result twice over time. The execution pipeline runs each instruction twice. The first result arrives on the first-result port. The block stores it in a free entry together with the instruction tag and the destination register. The entries form a small table, laid out like a reservation station.

The second, redundant result arrives later on the second-result port with the same tag. The block finds the stored entry by an associative tag search and compares the two values. One cycle later it reports one of two outcomes:

- **Retire:** the values agree, and the block reports the verified value with its tag and destination.
- **Reissue:** the values disagree. The instruction is marked faulty and only that instruction is sent back for a fresh execution. No pipeline flush takes place.

In both cases the entry becomes available again at that same edge. When both copies of an instruction arrive in the same cycle and nothing is stored for that tag, they are compared directly and no entry is used. The first-result port drops its ready signal while every entry is occupied, so no result is lost.

Top module: `dxv_buffer`

## Requirements
- R1: A first result offered while `first_ready` is high is stored with its tag, destination and value in a free entry, and `free_count` is one lower after that clock edge.
- R2: When all DEPTH entries are occupied, `full` is high and `first_ready` is low. A first result offered in that state is not stored, so a later second result with its tag yields no outcome.
- R3: A second result whose tag matches a stored entry and whose value equals the stored value gives, one cycle later, a single-cycle `retire_valid`. The pulse carries the stored tag, destination and value.
- R4: A second result whose tag matches a stored entry but whose value differs gives, one cycle later, `reissue_valid` with the stored tag and destination, and `retire_valid` stays low.
- R5: The matched entry is released at the same edge that registers the outcome, and `free_count` rises by one.
- R6: A second result whose tag matches no stored entry, and which is not paired with a same-tag first result, produces no outcome and changes no state.
- R7: A first result and a second result with equal tags in the same cycle, with no stored entry for that tag, are compared directly. The verdict follows one cycle later and no entry is consumed.
- R8: If a stored entry matches the second result's tag, that entry is used for the comparison even when a first result with the same tag arrives in the same cycle. That first result is then stored as a new entry.
- R9: An allocation and a release in the same cycle both take effect, and `free_count` is unchanged across that edge.
- R10: `retire_valid` and `reissue_valid` are never high together. With no second result in the previous cycle, both are low.
- R11: Reset empties the table: `free_count` equals DEPTH, `full` is low, `first_ready` is high, and both outcome strobes are low.
- R12: After a reissue, the same tag can enter again as a fresh first/second pair and is judged normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| first_valid | input | 1 | First result offered |
| first_ready | output | 1 | A free entry exists; first result can be taken |
| first_tag | input | TAG_W | Instruction tag of the first result |
| first_dest | input | DEST_W | Destination register of the instruction |
| first_data | input | DATA_W | First result value |
| second_valid | input | 1 | Redundant result offered (always accepted) |
| second_tag | input | TAG_W | Instruction tag of the redundant result |
| second_data | input | DATA_W | Redundant result value |
| retire_valid | output | 1 | Results agreed; instruction may retire |
| retire_tag | output | TAG_W | Tag of the retiring instruction |
| retire_dest | output | DEST_W | Destination of the retiring instruction |
| retire_data | output | DATA_W | Verified result value |
| reissue_valid | output | 1 | Results disagreed; instruction must run again |
| reissue_tag | output | TAG_W | Tag of the instruction to reissue |
| reissue_dest | output | DEST_W | Destination of the instruction to reissue |
| full | output | 1 | Every entry is occupied |
| free_count | output | CNT_W | Number of free entries |

## Verification
Two functions can fall in the same cycle.

- **Allocation and release together.** A new first result is stored while a second result releases another entry. The bench provokes this by driving both ports in one cycle against a partly filled table. It then checks that `free_count` has not moved and that the verdict carries the released entry's fields.
- **Bypass against a stored match.** A first result and a second result share a tag, once with an empty table and once with that tag already stored. The bench judges which value was used for the comparison from the outcome fields one cycle later. It also checks whether an entry was consumed, and whether a further second result with that tag finds the newly stored copy.

// File: rtl/dxv_pkg.sv
package dxv_pkg;

   typedef enum logic [1:0] {
      VERD_NONE    = 2'd0,
      VERD_RETIRE  = 2'd1,
      VERD_REISSUE = 2'd2
   } verdict_e;

endpackage

// File: rtl/dxv_alloc.sv
module dxv_alloc #(
   parameter int DEPTH       = 4,
   parameter bit PICK_LOWEST = 1'b1,
   localparam int IDX_W      = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] busy,
   output logic             has_free,
   output logic [IDX_W-1:0] idx
);

   if (PICK_LOWEST) begin : g_low
      always_comb begin
         idx      = '0;
         has_free = 1'b0;
         for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) begin
               idx      = IDX_W'(i);
               has_free = 1'b1;
            end
         end
      end
   end else begin : g_high
      always_comb begin
         idx      = '0;
         has_free = 1'b0;
         for (int i = 0; i < DEPTH; i++) begin
            if (!busy[i]) begin
               idx      = IDX_W'(i);
               has_free = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/dxv_match.sv
module dxv_match #(
   parameter int DEPTH  = 4,
   parameter int TAG_W  = 4,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                       en,
   input  logic [TAG_W-1:0]           key,
   input  logic [DEPTH-1:0]           live,
   input  logic [DEPTH-1:0][TAG_W-1:0] tags,
   output logic                       hit,
   output logic [IDX_W-1:0]           idx
);

   logic [DEPTH-1:0] hit_vec;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign hit_vec[g] = en && live[g] && (tags[g] == key);
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (hit_vec[i]) idx = IDX_W'(i);
      end
   end

   assign hit = |hit_vec;

endmodule

// File: rtl/dxv_judge.sv
module dxv_judge
   import dxv_pkg::*;
#(
   parameter int TAG_W  = 4,
   parameter int DEST_W = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_en,
   input  logic [TAG_W-1:0]  ref_tag,
   input  logic [DEST_W-1:0] ref_dest,
   input  logic [DATA_W-1:0] ref_data,
   input  logic [DATA_W-1:0] dup_data,
   output logic              retire_valid,
   output logic [TAG_W-1:0]  retire_tag,
   output logic [DEST_W-1:0] retire_dest,
   output logic [DATA_W-1:0] retire_data,
   output logic              reissue_valid,
   output logic [TAG_W-1:0]  reissue_tag,
   output logic [DEST_W-1:0] reissue_dest
);

   verdict_e verdict;

   always_comb begin
      if (!cmp_en)                    verdict = VERD_NONE;
      else if (ref_data == dup_data)  verdict = VERD_RETIRE;
      else                            verdict = VERD_REISSUE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         retire_valid  <= 1'b0;
         reissue_valid <= 1'b0;
         retire_tag    <= '0;
         retire_dest   <= '0;
         retire_data   <= '0;
         reissue_tag   <= '0;
         reissue_dest  <= '0;
      end else begin
         retire_valid  <= (verdict == VERD_RETIRE);
         reissue_valid <= (verdict == VERD_REISSUE);
         if (verdict == VERD_RETIRE) begin
            retire_tag  <= ref_tag;
            retire_dest <= ref_dest;
            retire_data <= ref_data;
         end
         if (verdict == VERD_REISSUE) begin
            reissue_tag  <= ref_tag;
            reissue_dest <= ref_dest;
         end
      end
   end

endmodule

// File: rtl/dxv_buffer.sv
module dxv_buffer #(
   parameter int DEPTH       = 4,
   parameter int TAG_W       = 4,
   parameter int DEST_W      = 5,
   parameter int DATA_W      = 16,
   parameter bit BYPASS_EN   = 1'b1,
   parameter bit PICK_LOWEST = 1'b1,
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_valid,
   output logic              first_ready,
   input  logic [TAG_W-1:0]  first_tag,
   input  logic [DEST_W-1:0] first_dest,
   input  logic [DATA_W-1:0] first_data,
   input  logic              second_valid,
   input  logic [TAG_W-1:0]  second_tag,
   input  logic [DATA_W-1:0] second_data,
   output logic              retire_valid,
   output logic [TAG_W-1:0]  retire_tag,
   output logic [DEST_W-1:0] retire_dest,
   output logic [DATA_W-1:0] retire_data,
   output logic              reissue_valid,
   output logic [TAG_W-1:0]  reissue_tag,
   output logic [DEST_W-1:0] reissue_dest,
   output logic              full,
   output logic [CNT_W-1:0]  free_count
);

   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dxv_buffer: DEPTH must be at least 2");
   end
   if (TAG_W < 1 || DEST_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("dxv_buffer: field widths must be positive");
   end
   if (DEPTH > (1 << TAG_W)) begin : g_bad_tags
      $error("dxv_buffer: more entries than distinct tags");
   end

   logic [DEPTH-1:0]              valid_q;
   logic [DEPTH-1:0][TAG_W-1:0]   tag_q;
   logic [DEPTH-1:0][DEST_W-1:0]  dest_q;
   logic [DEPTH-1:0][DATA_W-1:0]  data_q;

   logic             has_free;
   logic [IDX_W-1:0] alloc_idx;
   logic             hit;
   logic [IDX_W-1:0] hit_idx;
   logic             accept;
   logic             bypass_fire;
   logic             alloc_fire;
   logic             cmp_en;
   logic [TAG_W-1:0]  ref_tag;
   logic [DEST_W-1:0] ref_dest;
   logic [DATA_W-1:0] ref_data;
   logic [CNT_W-1:0]  used_cnt;

   dxv_alloc #(
      .DEPTH       (DEPTH),
      .PICK_LOWEST (PICK_LOWEST)
   ) u_alloc (
      .busy     (valid_q),
      .has_free (has_free),
      .idx      (alloc_idx)
   );

   dxv_match #(
      .DEPTH (DEPTH),
      .TAG_W (TAG_W)
   ) u_match (
      .en   (second_valid),
      .key  (second_tag),
      .live (valid_q),
      .tags (tag_q),
      .hit  (hit),
      .idx  (hit_idx)
   );

   assign first_ready = has_free;
   assign full        = !has_free;
   assign accept      = first_valid && has_free;

   if (BYPASS_EN) begin : g_bypass
      assign bypass_fire = accept && second_valid && !hit && (first_tag == second_tag);
   end else begin : g_no_bypass
      assign bypass_fire = 1'b0;
   end

   assign alloc_fire = accept && !bypass_fire;
   assign cmp_en     = hit || bypass_fire;

   always_comb begin
      if (hit) begin
         ref_tag  = tag_q[hit_idx];
         ref_dest = dest_q[hit_idx];
         ref_data = data_q[hit_idx];
      end else begin
         ref_tag  = first_tag;
         ref_dest = first_dest;
         ref_data = first_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc_fire && alloc_idx == IDX_W'(i)) begin
               valid_q[i] <= 1'b1;
            end else if (hit && hit_idx == IDX_W'(i)) begin
               valid_q[i] <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (alloc_fire && alloc_idx == IDX_W'(i)) begin
            tag_q[i]  <= first_tag;
            dest_q[i] <= first_dest;
            data_q[i] <= first_data;
         end
      end
   end

   always_comb begin
      used_cnt = '0;
      for (int i = 0; i < DEPTH; i++) begin
         used_cnt = used_cnt + CNT_W'(valid_q[i]);
      end
   end

   assign free_count = CNT_W'(DEPTH) - used_cnt;

   dxv_judge #(
      .TAG_W  (TAG_W),
      .DEST_W (DEST_W),
      .DATA_W (DATA_W)
   ) u_judge (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmp_en        (cmp_en),
      .ref_tag       (ref_tag),
      .ref_dest      (ref_dest),
      .ref_data      (ref_data),
      .dup_data      (second_data),
      .retire_valid  (retire_valid),
      .retire_tag    (retire_tag),
      .retire_dest   (retire_dest),
      .retire_data   (retire_data),
      .reissue_valid (reissue_valid),
      .reissue_tag   (reissue_tag),
      .reissue_dest  (reissue_dest)
   );

endmodule

// File: rtl/dxv_buffer_chk.sv
module dxv_buffer_chk #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              second_valid,
   input logic [DATA_W-1:0] second_data,
   input logic              full,
   input logic [CNT_W-1:0]  free_count,
   input logic              retire_valid,
   input logic [DATA_W-1:0] retire_data,
   input logic              reissue_valid,
   input logic              alloc_fire,
   input logic              hit,
   input logic              bypass_fire,
   input logic              cmp_en,
   input logic [DATA_W-1:0] ref_data
);

   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !(retire_valid && reissue_valid)); // R10

   AST_VERDICT_NEEDS_COMPARE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (retire_valid || reissue_valid) |-> $past(cmp_en)); // R3

   AST_RETIRE_VALUE_AGREES: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      retire_valid |-> (retire_data == $past(second_data))); // R3

   AST_REISSUE_VALUE_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      reissue_valid |-> ($past(ref_data) != $past(second_data))); // R4

   AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(full && !hit) |-> full); // R2

   AST_FREE_BALANCE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      int'(free_count) == int'($past(free_count)) - int'($past(alloc_fire)) + int'($past(hit))); // R9

   AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(second_valid && !hit && !bypass_fire) |-> (!retire_valid && !reissue_valid)); // R6

endmodule

bind dxv_buffer dxv_buffer_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .second_valid  (second_valid),
   .second_data   (second_data),
   .full          (full),
   .free_count    (free_count),
   .retire_valid  (retire_valid),
   .retire_data   (retire_data),
   .reissue_valid (reissue_valid),
   .alloc_fire    (alloc_fire),
   .hit           (hit),
   .bypass_fire   (bypass_fire),
   .cmp_en        (cmp_en),
   .ref_data      (ref_data)
);

// File: tb/dxv_buffer_bench.sv
module dxv_buffer_bench;

   localparam int DEPTH  = 4;
   localparam int TAG_W  = 4;
   localparam int DEST_W = 3;
   localparam int DATA_W = 8;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              first_valid = 1'b0;
   logic              first_ready;
   logic [TAG_W-1:0]  first_tag = '0;
   logic [DEST_W-1:0] first_dest = '0;
   logic [DATA_W-1:0] first_data = '0;
   logic              second_valid = 1'b0;
   logic [TAG_W-1:0]  second_tag = '0;
   logic [DATA_W-1:0] second_data = '0;
   logic              retire_valid;
   logic [TAG_W-1:0]  retire_tag;
   logic [DEST_W-1:0] retire_dest;
   logic [DATA_W-1:0] retire_data;
   logic              reissue_valid;
   logic [TAG_W-1:0]  reissue_tag;
   logic [DEST_W-1:0] reissue_dest;
   logic              full;
   logic [CNT_W-1:0]  free_count;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #2 clk = ~clk;

   dxv_buffer #(
      .DEPTH  (DEPTH),
      .TAG_W  (TAG_W),
      .DEST_W (DEST_W),
      .DATA_W (DATA_W)
   ) u_dxv_buffer (
      .clk           (clk),
      .rst_n         (rst_n),
      .first_valid   (first_valid),
      .first_ready   (first_ready),
      .first_tag     (first_tag),
      .first_dest    (first_dest),
      .first_data    (first_data),
      .second_valid  (second_valid),
      .second_tag    (second_tag),
      .second_data   (second_data),
      .retire_valid  (retire_valid),
      .retire_tag    (retire_tag),
      .retire_dest   (retire_dest),
      .retire_data   (retire_data),
      .reissue_valid (reissue_valid),
      .reissue_tag   (reissue_tag),
      .reissue_dest  (reissue_dest),
      .full          (full),
      .free_count    (free_count)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One clock: inputs set after the falling edge, outputs sampled 1 ns after the rising edge.
   task automatic drive(input bit fv, input int ft, input int fd, input int fdat,
                        input bit sv, input int st, input int sdat);
      @(negedge clk);
      first_valid  = fv;
      first_tag    = TAG_W'(ft);
      first_dest   = DEST_W'(fd);
      first_data   = DATA_W'(fdat);
      second_valid = sv;
      second_tag   = TAG_W'(st);
      second_data  = DATA_W'(sdat);
      @(posedge clk);
      #1;
      first_valid  = 1'b0;
      second_valid = 1'b0;
   endtask

   task automatic idle();
      drive(1'b0, 0, 0, 0, 1'b0, 0, 0);
   endtask

   task automatic expect_retire(input string req, input int tag, input int dest, input int data);
      chk(req, "retire_valid", int'(retire_valid), 1);
      chk(req, "reissue_valid", int'(reissue_valid), 0);
      chk(req, "retire_tag", int'(retire_tag), tag);
      chk(req, "retire_dest", int'(retire_dest), dest);
      chk(req, "retire_data", int'(retire_data), data);
   endtask

   task automatic expect_reissue(input string req, input int tag, input int dest);
      chk(req, "reissue_valid", int'(reissue_valid), 1);
      chk(req, "retire_valid", int'(retire_valid), 0);
      chk(req, "reissue_tag", int'(reissue_tag), tag);
      chk(req, "reissue_dest", int'(reissue_dest), dest);
   endtask

   task automatic expect_silent(input string req);
      chk(req, "retire_valid", int'(retire_valid), 0);
      chk(req, "reissue_valid", int'(reissue_valid), 0);
   endtask

   function automatic int val_of(input int k, input int rnd, input int n);
      return (k * 37 + rnd * 11 + n * 5) & 8'hFF;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      #0;
      // R11: reset state
      chk("R11", "free_count", int'(free_count), DEPTH);
      chk("R11", "full", int'(full), 0);
      chk("R11", "first_ready", int'(first_ready), 1);
      expect_silent("R11");

      // Sweep: fill n entries, then drain them in two orders with a mismatch pattern.
      for (int rnd = 0; rnd < 4; rnd++) begin
         for (int n = 1; n <= DEPTH; n++) begin
            for (int k = 0; k < n; k++) begin
               drive(1'b1, (k + rnd * 5) % 16, (k + rnd) % 8, val_of(k, rnd, n), 1'b0, 0, 0);
               chk("R1", "free_count after store", int'(free_count), DEPTH - k - 1);
            end
            chk("R2", "full", int'(full), (n == DEPTH) ? 1 : 0);
            chk("R2", "first_ready", int'(first_ready), (n == DEPTH) ? 0 : 1);
            for (int j = 0; j < n; j++) begin
               int k;
               bit mm;
               k  = (rnd % 2 == 1) ? (n - 1 - j) : j;
               mm = ((k + rnd) % 3 == 0);
               drive(1'b0, 0, 0, 0, 1'b1, (k + rnd * 5) % 16,
                     mm ? (val_of(k, rnd, n) ^ (1 << (k % 8))) : val_of(k, rnd, n));
               if (mm) expect_reissue("R4", (k + rnd * 5) % 16, (k + rnd) % 8);
               else    expect_retire("R3", (k + rnd * 5) % 16, (k + rnd) % 8, val_of(k, rnd, n));
               chk("R5", "free_count after verdict", int'(free_count), DEPTH - n + j + 1);
            end
            idle();
            expect_silent("R10");
         end
      end

      // R2: first result refused while full is not stored
      for (int k = 0; k < DEPTH; k++) drive(1'b1, k, 1, 8'h40 + k, 1'b0, 0, 0);
      drive(1'b1, 9, 2, 8'h99, 1'b0, 0, 0);
      chk("R2", "free_count while full", int'(free_count), 0);
      drive(1'b0, 0, 0, 0, 1'b1, 0, 8'h40);
      expect_retire("R3", 0, 1, 8'h40);
      drive(1'b0, 0, 0, 0, 1'b1, 9, 8'h99);
      expect_silent("R2");
      chk("R2", "free_count after refused tag", int'(free_count), 1);

      // R9: store and release in the same cycle
      drive(1'b1, 12, 6, 8'h5A, 1'b1, 1, 8'h41);
      expect_retire("R9", 1, 1, 8'h41);
      chk("R9", "free_count unchanged", int'(free_count), 1);

      // R6: unknown tag is ignored
      drive(1'b0, 0, 0, 0, 1'b1, 7, 8'h11);
      expect_silent("R6");
      chk("R6", "free_count", int'(free_count), 1);
      for (int k = 2; k < DEPTH; k++) begin
         drive(1'b0, 0, 0, 0, 1'b1, k, 8'h40 + k);
         expect_retire("R3", k, 1, 8'h40 + k);
      end
      drive(1'b0, 0, 0, 0, 1'b1, 12, 8'h5B);
      expect_reissue("R4", 12, 6);
      chk("R5", "table empty", int'(free_count), DEPTH);

      // R7: same-cycle bypass, both outcomes
      drive(1'b1, 3, 4, 8'h22, 1'b1, 3, 8'h22);
      expect_retire("R7", 3, 4, 8'h22);
      chk("R7", "no entry used", int'(free_count), DEPTH);
      drive(1'b1, 5, 2, 8'h22, 1'b1, 5, 8'h23);
      expect_reissue("R7", 5, 2);
      chk("R7", "no entry used", int'(free_count), DEPTH);

      // R8: stored match wins over bypass; new first is stored
      drive(1'b1, 2, 1, 8'hA0, 1'b0, 0, 0);
      drive(1'b1, 2, 5, 8'hB0, 1'b1, 2, 8'hA0);
      expect_retire("R8", 2, 1, 8'hA0);
      chk("R8", "free_count", int'(free_count), DEPTH - 1);
      drive(1'b0, 0, 0, 0, 1'b1, 2, 8'hB0);
      expect_retire("R8", 2, 5, 8'hB0);
      chk("R8", "free_count", int'(free_count), DEPTH);

      // R12: reissued tag re-enters as a fresh pair
      drive(1'b1, 7, 3, 8'h10, 1'b0, 0, 0);
      drive(1'b0, 0, 0, 0, 1'b1, 7, 8'h11);
      expect_reissue("R12", 7, 3);
      drive(1'b1, 7, 3, 8'h10, 1'b0, 0, 0);
      drive(1'b0, 0, 0, 0, 1'b1, 7, 8'h10);
      expect_retire("R12", 7, 3, 8'h10);
      idle();
      expect_silent("R10");

      // R11: reset mid-operation empties the table
      drive(1'b1, 4, 0, 8'h01, 1'b0, 0, 0);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      chk("R11", "free_count after reset", int'(free_count), DEPTH);
      drive(1'b0, 0, 0, 0, 1'b1, 4, 8'h01);
      expect_silent("R11");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule